// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block sits right behind the instruction memory of a simple 64-bit processor. It receives a window of up to ten bytes that begins at the current program counter. From that window it splits out the operation fields, the register specifiers and the embedded 64-bit constant. It then reports how many bytes the instruction occupies, where the next sequential instruction begins, and a status code for the fetch stage.

The first byte alone sets the layout of the instruction. Its high nibble selects the operation class and its low nibble selects a variant within that class. Some classes add one byte of register specifiers. Some add an eight-byte little-endian constant, and that constant moves by one byte when the register byte is present. The whole block is combinational, so a fetch stage can feed the window and the program counter in one cycle and register the outputs at its own boundary.

Top module: `fetch_decode`

## Requirements
- R1: `icode_o` equals bits [7:4] of the first window byte (`win_i[7:0]`), and `ifun_o` equals bits [3:0] of that byte.
- R2: `instr_valid_o` is 1 only for these pairs: classes 0x2 and 0x7 with variant 0..6; class 0x6 with variant 0..3; classes 0x0, 0x1, 0x3, 0x4, 0x5, 0x8, 0x9, 0xA and 0xB with variant 0. Classes 0xC..0xF are never valid.
- R3: Classes 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB carry a register byte at window byte 1. For these classes, `ra_o` is that byte's high nibble and `rb_o` is its low nibble. For every other class, both outputs are 0xF.
- R4: Classes 0x3, 0x4, 0x5, 0x7 and 0x8 carry an 8-byte constant, least significant byte first. It starts at window byte 2 when a register byte is present and at window byte 1 otherwise. For every other class, `valc_o` is zero.
- R5: `len_o` equals 1 + (register byte ? 1 : 0) + (constant ? 8 : 0), so it is always 1, 2, 9 or 10. Classes 0xC..0xF give 1.
- R6: `valp_o` equals `pc_i + len_o` modulo 2^64.
- R7: `stat_o` follows a fixed priority. It is 3 when `imem_err_i` is high. Otherwise it is 4 when the instruction is invalid (R2), 2 for a valid halt (byte 0x00), and 1 in all other cases. Field outputs are decoded as usual whatever the status.
- R8: An all-zero window decodes as a one-byte halt: status 2, length 1, `valp_o = pc_i + 1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 64 | Address of the first window byte |
| win_i | input | 80 | Fetched bytes; byte k at bits [8k+7:8k] |
| imem_err_i | input | 1 | Instruction memory reported an address fault |
| icode_o | output | 4 | Operation class |
| ifun_o | output | 4 | Variant within the class |
| ra_o | output | 4 | First register specifier, 0xF when absent |
| rb_o | output | 4 | Second register specifier, 0xF when absent |
| valc_o | output | 64 | Embedded constant, zero when absent |
| len_o | output | 4 | Instruction length in bytes |
| valp_o | output | 64 | Address of the next sequential instruction |
| instr_valid_o | output | 1 | Class and variant form a legal pair |
| stat_o | output | 3 | 1 normal, 2 halt, 3 address fault, 4 invalid |

## Verification
The bench sweeps all 256 first-byte values, with and without a memory fault, under three sets of window contents and program counters.

- **Constant position.** It checks that the constant is taken from the shifted position exactly when a register byte exists. A design that ignored the shift would return a constant holding the register byte in its lowest lane.
- **Variant limits.** It probes the edges of the legal variant ranges: 6 against 7 for moves and jumps, 3 against 4 for arithmetic. A comparison off by one would pass an illegal variant or reject a legal one.
- **Address wrap.** A program counter just below 2^64 checks that the next address wraps.
- **Status order.** Faulted fetches of invalid and halt bytes confirm that the address fault outranks every other status.

// File: rtl/fd_pkg.sv
package fd_pkg;

  typedef enum logic [3:0] {
    OP_HALT = 4'h0, OP_NOP  = 4'h1, OP_MOVC = 4'h2, OP_MOVI = 4'h3,
    OP_STOR = 4'h4, OP_LOAD = 4'h5, OP_ALU  = 4'h6, OP_JMP  = 4'h7,
    OP_CALL = 4'h8, OP_RET  = 4'h9, OP_PUSH = 4'hA, OP_POP  = 4'hB
  } op_e;

  typedef enum logic [2:0] {
    ST_AOK = 3'd1, ST_HLT = 3'd2, ST_ADR = 3'd3, ST_INS = 3'd4
  } stat_e;

  localparam logic [3:0] REG_NONE = 4'hF;

  // legal class/variant pairs
  function automatic logic pair_legal(input logic [3:0] op, input logic [3:0] fn);
    case (op)
      OP_MOVC, OP_JMP: return fn <= 4'd6;
      OP_ALU:          return fn <= 4'd3;
      OP_HALT, OP_NOP, OP_MOVI, OP_STOR, OP_LOAD,
      OP_CALL, OP_RET, OP_PUSH, OP_POP: return fn == 4'd0;
      default:         return 1'b0;
    endcase
  endfunction

  function automatic logic carries_reg(input logic [3:0] op);
    case (op)
      OP_MOVC, OP_MOVI, OP_STOR, OP_LOAD, OP_ALU, OP_PUSH, OP_POP: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic carries_const(input logic [3:0] op);
    case (op)
      OP_MOVI, OP_STOR, OP_LOAD, OP_JMP, OP_CALL: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // byte count: opcode byte, optional register byte, optional constant
  function automatic int unsigned byte_count(input logic has_r, input logic has_c,
                                             input int unsigned cbytes);
    return 1 + (has_r ? 1 : 0) + (has_c ? cbytes : 0);
  endfunction

endpackage

// File: rtl/fd_class.sv
module fd_class
  import fd_pkg::*;
#(
  parameter int unsigned WORD_BYTES = 8,
  localparam int unsigned LEN_W = $clog2(WORD_BYTES + 3)
) (
  input  logic [3:0]       op_i,
  input  logic [3:0]       fn_i,
  output logic             legal_o,
  output logic             has_reg_o,
  output logic             has_const_o,
  output logic [LEN_W-1:0] len_o
);
  always_comb begin
    legal_o     = pair_legal(op_i, fn_i);
    has_reg_o   = carries_reg(op_i);
    has_const_o = carries_const(op_i);
    len_o       = LEN_W'(byte_count(has_reg_o, has_const_o, WORD_BYTES));
  end
endmodule

// File: rtl/fd_extract.sv
module fd_extract
  import fd_pkg::*;
#(
  parameter int unsigned WORD_BYTES = 8,
  localparam int unsigned WIN_BYTES = WORD_BYTES + 2
) (
  input  logic [8*WIN_BYTES-1:0]  win_i,
  input  logic                    has_reg_i,
  input  logic                    has_const_i,
  output logic [3:0]              ra_o,
  output logic [3:0]              rb_o,
  output logic [8*WORD_BYTES-1:0] valc_o
);
  logic [8*WORD_BYTES-1:0] lanes;

  assign ra_o = has_reg_i ? win_i[15:12] : REG_NONE;
  assign rb_o = has_reg_i ? win_i[11:8]  : REG_NONE;

  // each constant lane picks from one of two window bytes
  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
    assign lanes[8*k +: 8] = has_reg_i ? win_i[8*(k+2) +: 8] : win_i[8*(k+1) +: 8];
  end

  assign valc_o = has_const_i ? lanes : '0;
endmodule

// File: rtl/fd_nextpc.sv
module fd_nextpc #(
  parameter int unsigned PC_W  = 64,
  parameter int unsigned LEN_W = 4
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [PC_W-1:0]  valp_o
);
  assign valp_o = pc_i + {{(PC_W-LEN_W){1'b0}}, len_i};
endmodule

// File: rtl/fetch_decode.sv
module fetch_decode
  import fd_pkg::*;
#(
  parameter int unsigned PC_W       = 64,
  parameter int unsigned WORD_BYTES = 8,
  localparam int unsigned WIN_BYTES = WORD_BYTES + 2,
  localparam int unsigned LEN_W     = $clog2(WORD_BYTES + 3)
) (
  input  logic [PC_W-1:0]         pc_i,
  input  logic [8*WIN_BYTES-1:0]  win_i,
  input  logic                    imem_err_i,
  output logic [3:0]              icode_o,
  output logic [3:0]              ifun_o,
  output logic [3:0]              ra_o,
  output logic [3:0]              rb_o,
  output logic [8*WORD_BYTES-1:0] valc_o,
  output logic [LEN_W-1:0]        len_o,
  output logic [PC_W-1:0]         valp_o,
  output logic                    instr_valid_o,
  output logic [2:0]              stat_o
);
  localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_TWO  = LEN_W'(2);
  localparam logic [LEN_W-1:0] LEN_CST  = LEN_W'(WORD_BYTES + 1);
  localparam logic [LEN_W-1:0] LEN_BOTH = LEN_W'(WORD_BYTES + 2);

  // named internal events
  logic legal_w, reg_w, const_w, halt_w;
  stat_e stat_w;

  assign icode_o = win_i[7:4];
  assign ifun_o  = win_i[3:0];

  fd_class #(.WORD_BYTES(WORD_BYTES)) u_class (
    .op_i(icode_o), .fn_i(ifun_o), .legal_o(legal_w),
    .has_reg_o(reg_w), .has_const_o(const_w), .len_o(len_o)
  );

  fd_extract #(.WORD_BYTES(WORD_BYTES)) u_extract (
    .win_i(win_i), .has_reg_i(reg_w), .has_const_i(const_w),
    .ra_o(ra_o), .rb_o(rb_o), .valc_o(valc_o)
  );

  fd_nextpc #(.PC_W(PC_W), .LEN_W(LEN_W)) u_nextpc (
    .pc_i(pc_i), .len_i(len_o), .valp_o(valp_o)
  );

  assign halt_w        = legal_w && (icode_o == OP_HALT);
  assign instr_valid_o = legal_w;

  // fault first, then invalid, then halt
  always_comb begin
    if (imem_err_i)    stat_w = ST_ADR;
    else if (!legal_w) stat_w = ST_INS;
    else if (halt_w)   stat_w = ST_HLT;
    else               stat_w = ST_AOK;
  end
  assign stat_o = stat_w;

  always_comb begin
    if (!$isunknown({pc_i, win_i, imem_err_i})) begin
      AST_LEN_SET: assert (len_o == LEN_ONE || len_o == LEN_TWO ||
                           len_o == LEN_CST || len_o == LEN_BOTH); // R5
      AST_NOREG_F: assert (reg_w || (ra_o == REG_NONE && rb_o == REG_NONE)); // R3
      AST_CONST_ZERO: assert (const_w || valc_o == '0); // R4
      AST_VALP_DIST: assert (valp_o - pc_i == {{(PC_W-LEN_W){1'b0}}, len_o}); // R6
      AST_FAULT_WINS: assert (!imem_err_i || stat_o == 3'd3); // R7
      AST_BAD_IS_INS: assert (imem_err_i || legal_w || stat_o == 3'd4); // R2
    end
  end
endmodule

// File: tb/sim_fetch_decode.sv
module sim_fetch_decode;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [63:0] pc;
  logic [79:0] win;
  logic        err;
  logic [3:0]  icode, ifun, ra, rb, len;
  logic [63:0] valc, valp;
  logic        vld;
  logic [2:0]  stat;

  fetch_decode u0 (
    .pc_i(pc), .win_i(win), .imem_err_i(err),
    .icode_o(icode), .ifun_o(ifun), .ra_o(ra), .rb_o(rb),
    .valc_o(valc), .len_o(len), .valp_o(valp),
    .instr_valid_o(vld), .stat_o(stat)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] wbyte(input logic [79:0] w, input int k);
    return w[8*k +: 8];
  endfunction

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    pc = '0; win = '0; err = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // R8: zero window
    @(posedge clk);
    pc = 64'h40; win = '0; err = 1'b0;
    @(negedge clk);
    chk("R8", "stat", 64'(stat), 64'd2);
    chk("R8", "len", 64'(len), 64'd1);
    chk("R8", "valp", valp, 64'h41);

    for (int p = 0; p < 3; p++) begin
      for (int b0 = 0; b0 < 256; b0++) begin
        for (int e = 0; e < 2; e++) begin
          logic [3:0] op, fn;
          logic e_ok, e_reg, e_cst;
          logic [3:0] e_len, e_ra, e_rb;
          logic [63:0] e_valc, e_pc;
          logic [2:0] e_st;
          int start;
          @(posedge clk);
          win[7:0] = 8'(b0);
          win[15:8] = 8'((b0*7 + p*53 + 1) & 8'hFF);
          for (int k = 2; k < 10; k++) win[8*k +: 8] = 8'((b0 + k*37 + p*101) & 8'hFF);
          case (p)
            0: e_pc = 64'h0;
            1: e_pc = 64'h1000 + 64'(b0);
            default: e_pc = 64'hFFFF_FFFF_FFFF_FFFC;
          endcase
          pc = e_pc;
          err = e[0];
          op = 4'(b0 >> 4);
          fn = 4'(b0 & 15);
          case (op)
            4'h2, 4'h7: e_ok = (fn < 7);
            4'h6:       e_ok = (fn < 4);
            4'h0, 4'h1, 4'h3, 4'h4, 4'h5, 4'h8, 4'h9, 4'hA, 4'hB: e_ok = (fn == 0);
            default:    e_ok = 1'b0;
          endcase
          e_reg = (op inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB});
          e_cst = (op inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8});
          e_len = 4'd1 + (e_reg ? 4'd1 : 4'd0) + (e_cst ? 4'd8 : 4'd0);
          e_ra = e_reg ? win[15:12] : 4'hF;
          e_rb = e_reg ? win[11:8]  : 4'hF;
          start = e_reg ? 2 : 1;
          e_valc = '0;
          if (e_cst)
            for (int k = 7; k >= 0; k--) e_valc = (e_valc << 8) | 64'(wbyte(win, start + k));
          if (e[0])       e_st = 3'd3;
          else if (!e_ok) e_st = 3'd4;
          else if (op == 4'h0) e_st = 3'd2;
          else            e_st = 3'd1;
          @(negedge clk);
          chk("R1", "icode", 64'(icode), 64'(op));
          chk("R1", "ifun", 64'(ifun), 64'(fn));
          chk("R2", "valid", 64'(vld), 64'(e_ok));
          chk("R3", "ra", 64'(ra), 64'(e_ra));
          chk("R3", "rb", 64'(rb), 64'(e_rb));
          chk("R4", "valc", valc, e_valc);
          chk("R5", "len", 64'(len), 64'(e_len));
          chk("R6", "valp", valp, e_pc + 64'(e_len));
          chk("R7", "stat", 64'(stat), 64'(e_st));
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule